// File: doc/BRIEF.md
# Multiplexed Bus Static RAM Glue

This block sits between the expansion bus of an 8-bit microcontroller and a byte-wide static RAM. The bus carries the upper address byte on a port of its own. The lower address byte and the data byte take turns on one shared lane. In the low half of the bus clock, an address-strobe pulse captures the lower address byte into a holding register, which keeps it for the rest of the bus cycle. The three most significant address bits, gated by the bus clock, select the RAM through its active-low chip enable. The active-low write and output strobes come from the bus clock and the read/write line.

Every RAM strobe can be active only while the bus clock is high. A transfer therefore completes within a single bus cycle, and the bus has no way to stretch a cycle. The shared lane is modelled as an input bus, an output bus and an output-enable. On a read, the block drives the lane only while the chip enable and the output strobe are both active, so the lane is free again before the next address phase.

A behavioural array stands in for the RAM. Its depth is a parameter. When the array is smaller than the decoded window, the window offset bits above the array depth are ignored, so the array repeats within the window.

Top module: `mbus_sram_glue`

## Requirements
- R1: While `bus_e` is low and `addr_stb` is high, the low address register loads `ad_in` at each rising `clk` edge. In every other cycle, including a strobe while `bus_e` is high, it keeps its value.
- R2: `ram_ce_n` is low exactly when `bus_e` is high and `addr_hi[7:5]` equals 3'b001, which is the window 0x2000 to 0x3FFF.
- R3: `ram_we_n` is low exactly when `bus_e` is high and `bus_rd` is 0. `ram_oe_n` is low exactly when `bus_e` is high and `bus_rd` is 1. The two strobes are never low together.
- R4: While `bus_e` is low, `ram_ce_n`, `ram_we_n` and `ram_oe_n` are all high and `ad_oe` is low.
- R5: At each rising `clk` edge where `ram_ce_n` and `ram_we_n` are both low, the array stores `ad_in` at the offset formed by `addr_hi[4:0]` followed by the low address register.
- R6: `ad_oe` is high exactly when `ram_ce_n` and `ram_oe_n` are both low. `ad_out` then shows the array byte at the current offset.
- R7: An access outside the window neither writes the array nor drives the lane.
- R8: Offset bits at or above the array address width (default 11 bits) are ignored. For example, 0x2805 and 0x2005 reach the same byte.
- R9: Synchronous reset clears the low address register to 0 and leaves the array contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_e | input | 1 | Bus clock; high half carries data |
| addr_stb | input | 1 | Address strobe for the low address byte |
| bus_rd | input | 1 | 1 = read, 0 = write |
| addr_hi | input | 8 | Upper address byte |
| ad_in | input | 8 | Shared lane, value driven by the bus |
| ad_out | output | 8 | Shared lane, value driven by the block |
| ad_oe | output | 1 | Block drives the shared lane |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_we_n | output | 1 | RAM write strobe, active low |
| ram_oe_n | output | 1 | RAM output strobe, active low |

## Verification
The assertions check the following on every cycle: the strobes stay inactive during the low half of the bus clock, the write and output strobes are never active together, the chip enable asserts only for the selected window, the lane is driven only under an active read, and the low address register changes only under a low-half strobe. Only the bench scenarios show that data really round-trips through the array. These scenarios also cover window aliasing, writes outside the window being dropped, a strobe in the high half being ignored, and array contents surviving a reset.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    localparam int HI_W_DEF   = 8;
    localparam int LO_W_DEF   = 8;
    localparam int DATA_W_DEF = 8;
    localparam int SEL_W_DEF  = 3;
    localparam int ARR_AW_DEF = 11;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
    } ram_ctl_t;

    localparam ram_ctl_t RAM_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};

    typedef enum logic {
        DIR_WRITE = 1'b0,
        DIR_READ  = 1'b1
    } bus_dir_e;

    function automatic logic window_hit(input logic [SEL_W_DEF-1:0] sel,
                                        input logic [SEL_W_DEF-1:0] match);
        return sel == match;
    endfunction

endpackage

// File: rtl/mbus_lo_latch.sv
module mbus_lo_latch #(
    parameter int LO_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_e,
    input  logic            addr_stb,
    input  logic [LO_W-1:0] lane_in,
    output logic [LO_W-1:0] lo_q
);
    logic capture;

    assign capture = addr_stb && !bus_e;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
        end else if (capture) begin
            lo_q <= lane_in;
        end
    end
endmodule

// File: rtl/mbus_cs_decode.sv
module mbus_cs_decode
    import mbus_pkg::*;
#(
    parameter int                 SEL_W = 3,
    parameter logic [SEL_W-1:0]   MATCH = 3'b001
) (
    input  logic             bus_e,
    input  logic [SEL_W-1:0] sel,
    output logic             ce_n
);
    localparam int LINES = 2 ** SEL_W;

    logic [LINES-1:0] line_act;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        assign line_act[g] = bus_e && (sel == SEL_W'(g));
    end

    assign ce_n = ~line_act[MATCH];
endmodule

// File: rtl/mbus_strobe_gen.sv
module mbus_strobe_gen
    import mbus_pkg::*;
(
    input  logic     bus_e,
    input  logic     bus_rd,
    input  logic     ce_n,
    output ram_ctl_t ctl
);
    bus_dir_e dir;

    assign dir = bus_dir_e'(bus_rd);

    always_comb begin
        ctl      = RAM_IDLE;
        ctl.ce_n = ce_n;
        if (bus_e) begin
            ctl.we_n = (dir != DIR_WRITE);
            ctl.oe_n = (dir != DIR_READ);
        end
    end
endmodule

// File: rtl/mbus_sram_model.sv
module mbus_sram_model
    import mbus_pkg::*;
#(
    parameter int OFF_W  = 13,
    parameter int ARR_AW = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  ram_ctl_t          ctl,
    input  logic [OFF_W-1:0]  offset,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              drive
);
    localparam int DEPTH = 2 ** ARR_AW;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ARR_AW-1:0] idx;

    assign idx = offset[ARR_AW-1:0];

    always_ff @(posedge clk) begin
        if (!ctl.ce_n && !ctl.we_n) begin
            mem[idx] <= wdata;
        end
    end

    assign drive = !ctl.ce_n && !ctl.oe_n;
    assign rdata = drive ? mem[idx] : '0;
endmodule

// File: rtl/mbus_sram_glue.sv
module mbus_sram_glue
    import mbus_pkg::*;
#(
    parameter int                   HI_W   = HI_W_DEF,
    parameter int                   LO_W   = LO_W_DEF,
    parameter int                   DATA_W = DATA_W_DEF,
    parameter int                   SEL_W  = SEL_W_DEF,
    parameter logic [SEL_W-1:0]     WIN    = 3'b001,
    parameter int                   ARR_AW = ARR_AW_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_e,
    input  logic              addr_stb,
    input  logic              bus_rd,
    input  logic [HI_W-1:0]   addr_hi,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              ram_ce_n,
    output logic              ram_we_n,
    output logic              ram_oe_n
);
    localparam int HI_OFF_W = HI_W - SEL_W;
    localparam int OFF_W    = HI_OFF_W + LO_W;

    logic [LO_W-1:0]  lo_q;
    logic             ce_n;
    ram_ctl_t         ctl;
    logic [OFF_W-1:0] offset;

    mbus_lo_latch #(.LO_W(LO_W)) u_lo (
        .clk      (clk),
        .rst      (rst),
        .bus_e    (bus_e),
        .addr_stb (addr_stb),
        .lane_in  (ad_in[LO_W-1:0]),
        .lo_q     (lo_q)
    );

    mbus_cs_decode #(.SEL_W(SEL_W), .MATCH(WIN)) u_dec (
        .bus_e (bus_e),
        .sel   (addr_hi[HI_W-1:HI_W-SEL_W]),
        .ce_n  (ce_n)
    );

    mbus_strobe_gen u_stb (
        .bus_e  (bus_e),
        .bus_rd (bus_rd),
        .ce_n   (ce_n),
        .ctl    (ctl)
    );

    assign offset = {addr_hi[HI_OFF_W-1:0], lo_q};

    mbus_sram_model #(.OFF_W(OFF_W), .ARR_AW(ARR_AW), .DATA_W(DATA_W)) u_ram (
        .clk    (clk),
        .ctl    (ctl),
        .offset (offset),
        .wdata  (ad_in),
        .rdata  (ad_out),
        .drive  (ad_oe)
    );

    assign ram_ce_n = ctl.ce_n;
    assign ram_we_n = ctl.we_n;
    assign ram_oe_n = ctl.oe_n;
endmodule

// File: rtl/mbus_sram_glue_chk.sv
module mbus_sram_glue_chk #(
    parameter int               HI_W  = 8,
    parameter int               LO_W  = 8,
    parameter int               SEL_W = 3,
    parameter logic [SEL_W-1:0] WIN   = 3'b001
) (
    input logic            clk,
    input logic            rst,
    input logic            bus_e,
    input logic            addr_stb,
    input logic            bus_rd,
    input logic [HI_W-1:0] addr_hi,
    input logic [LO_W-1:0] lo_q,
    input logic            ad_oe,
    input logic            ram_ce_n,
    input logic            ram_we_n,
    input logic            ram_oe_n
);
    a_r4_quiet_low_half: assert property (@(posedge clk) disable iff (rst)
        !bus_e |-> (ram_ce_n && ram_we_n && ram_oe_n && !ad_oe));

    a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(!ram_we_n && !ram_oe_n));

    a_r3_write_dir: assert property (@(posedge clk) disable iff (rst)
        !ram_we_n |-> (bus_e && !bus_rd));

    a_r2_window_only: assert property (@(posedge clk) disable iff (rst)
        !ram_ce_n |-> (addr_hi[HI_W-1:HI_W-SEL_W] == WIN));

    a_r7_no_drive_outside: assert property (@(posedge clk) disable iff (rst)
        (addr_hi[HI_W-1:HI_W-SEL_W] != WIN) |-> (ram_ce_n && !ad_oe));

    a_r6_drive_on_read: assert property (@(posedge clk) disable iff (rst)
        ad_oe |-> (!ram_ce_n && !ram_oe_n && bus_rd));

    a_r1_hold_lo: assert property (@(posedge clk) disable iff (rst)
        !(addr_stb && !bus_e) |=> $stable(lo_q));
endmodule

bind mbus_sram_glue mbus_sram_glue_chk #(
    .HI_W(HI_W), .LO_W(LO_W), .SEL_W(SEL_W), .WIN(WIN)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_e    (bus_e),
    .addr_stb (addr_stb),
    .bus_rd   (bus_rd),
    .addr_hi  (addr_hi),
    .lo_q     (lo_q),
    .ad_oe    (ad_oe),
    .ram_ce_n (ram_ce_n),
    .ram_we_n (ram_we_n),
    .ram_oe_n (ram_oe_n)
);

// File: tb/test_mbus_sram_glue.sv
module test_mbus_sram_glue;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_e = 1'b0;
    logic       addr_stb = 1'b0;
    logic       bus_rd = 1'b1;
    logic [7:0] addr_hi = 8'h00;
    logic [7:0] ad_in = 8'h00;
    logic [7:0] ad_out;
    logic       ad_oe;
    logic       ram_ce_n, ram_we_n, ram_oe_n;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic [7:0] model [2048];

    always #10 clk = ~clk;

    mbus_sram_glue i_mbus_sram_glue (
        .clk(clk), .rst(rst), .bus_e(bus_e), .addr_stb(addr_stb),
        .bus_rd(bus_rd), .addr_hi(addr_hi), .ad_in(ad_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .ram_ce_n(ram_ce_n),
        .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n)
    );

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [7:0]  data;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 16'h2005, 8'hA5},
        '{1'b1, 16'h2100, 8'h3C},
        '{1'b1, 16'h27FF, 8'hE1},
        '{1'b1, 16'h4005, 8'h5A},
        '{1'b1, 16'h0100, 8'hC3},
        '{1'b0, 16'h2005, 8'h00},
        '{1'b0, 16'h2100, 8'h00},
        '{1'b0, 16'h27FF, 8'h00},
        '{1'b0, 16'h4005, 8'h00},
        '{1'b0, 16'hE100, 8'h00}
    };

    task automatic check(input string req, input logic [31:0] got,
                         input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic in_win(input logic [15:0] a);
        return a[15:13] == 3'b001;
    endfunction

    // One bus cycle: two clocks of E low, two of E high.
    task automatic bus_cycle(input logic wr, input logic [15:0] a,
                             input logic [7:0] d, input logic do_as,
                             input logic stray, input logic [7:0] stray_lo,
                             output logic got_oe, output logic [7:0] got_d);
        @(negedge clk);
        bus_e = 1'b0; bus_rd = ~wr; addr_hi = a[15:8];
        ad_in = a[7:0]; addr_stb = do_as;
        @(negedge clk);
        addr_stb = 1'b0; ad_in = 8'hEE;
        check("R4 strobes idle in low half",
              {ram_ce_n, ram_we_n, ram_oe_n, ad_oe}, 4'b1110);
        @(negedge clk);
        bus_e = 1'b1;
        if (wr) ad_in = d;
        if (stray) begin addr_stb = 1'b1; ad_in = stray_lo; end
        @(negedge clk);
        addr_stb = 1'b0;
        check("R2 chip enable decode", ram_ce_n, !in_win(a));
        check("R3 write strobe", ram_we_n, !wr);
        check("R3 output strobe", ram_oe_n, wr);
        got_oe = ad_oe; got_d = ad_out;
        @(negedge clk);
        bus_e = 1'b0; ad_in = 8'h00;
        if (wr && in_win(a)) model[a[10:0]] = d;
    endtask

    initial begin
        logic       oe;
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        check("R9 reset strobes idle", {ram_ce_n, ram_we_n, ram_oe_n, ad_oe}, 4'b1110);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            bus_cycle(VECS[i].wr, VECS[i].addr, VECS[i].data, 1'b1, 1'b0, 8'h00, oe, rd);
            if (!VECS[i].wr) begin
                check("R6/R7 lane drive", oe, in_win(VECS[i].addr));
                if (in_win(VECS[i].addr))
                    check("R5/R6 read data", rd, model[VECS[i].addr[10:0]]);
            end
        end

        // R7: outside writes dropped, window byte still A5
        bus_cycle(1'b0, 16'h2005, 8'h00, 1'b1, 1'b0, 8'h00, oe, rd);
        check("R7 outside write ignored", rd, 8'hA5);

        // R8: aliasing above array depth
        bus_cycle(1'b1, 16'h2805, 8'h91, 1'b1, 1'b0, 8'h00, oe, rd);
        bus_cycle(1'b0, 16'h2005, 8'h00, 1'b1, 1'b0, 8'h00, oe, rd);
        check("R8 alias read", rd, 8'h91);

        // R1: strobe in high half ignored
        bus_cycle(1'b0, 16'h2100, 8'h00, 1'b1, 1'b1, 8'h05, oe, rd);
        check("R1 high-half strobe ignored", rd, 8'h3C);
        bus_cycle(1'b0, 16'h2100, 8'h00, 1'b0, 1'b0, 8'h00, oe, rd);
        check("R1 low address held", rd, 8'h3C);

        // R9: reset clears low address, keeps array
        bus_cycle(1'b1, 16'h2000, 8'h77, 1'b1, 1'b0, 8'h00, oe, rd);
        bus_cycle(1'b0, 16'h27FF, 8'h00, 1'b1, 1'b0, 8'h00, oe, rd);
        check("R9 pre-reset read", rd, 8'hE1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        bus_cycle(1'b0, 16'h2000, 8'h00, 1'b0, 1'b0, 8'h00, oe, rd);
        check("R9 low address cleared, array kept", rd, 8'h77);
        check("R6 drive after reset", oe, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule